// File: doc/BRIEF.md
# Eight-Channel Sprite DMA Sequencer

This block keeps the per-line DMA bookkeeping for eight hardware sprites and fetches their image bytes from video memory. At one check point in every raster line, marked by a single-cycle `line_start` pulse, each channel decides whether its sprite starts, continues or ends DMA on that line. The block then publishes the new DMA mask and walks the active sprites in index order. For each active sprite it reads one pointer byte and then three image bytes.

The image bytes land in a back buffer. The front and back buffers trade places at the next check point, so the pixel logic downstream reads a stable copy of the previous line's fetch while the current line is fetched. A bus request is raised for exactly the cycles in which memory reads are being made on behalf of sprites, so the processor can be held off the bus. Memory is modelled as a combinational read port: the byte for `mem_addr` is returned on `mem_data` in the same cycle.

Top module: `sprite_dma_seq`

## Requirements
- R1: While reset is held, and after it is released, `dma_mask`, `bus_req`, `mem_rd` and every bit of `spr_data` read 0.
- R2: A channel that is not in DMA begins DMA on a check when all three of these hold: its `spr_en` bit is 1, its 8-bit `spr_ypos` equals `raster_y`, and it is not already running. A channel that is disabled, or whose Y position does not match, stays out of DMA.
- R3: On DMA start the row offset becomes 0, the expand toggle becomes the inverse of the sprite's `spr_yexp` bit, and the step becomes 3 when the toggle is 1 and 0 otherwise. On each later check while running, the step is added to the offset modulo 64. The toggle then inverts if `spr_yexp` is 1 at that check, and the step is recomputed from the toggle. A sprite without expansion therefore fetches offsets 0,3,…,60 on 21 lines; an expanded one fetches each of them on two lines.
- R4: A check that makes the offset 63 ends that channel's DMA and clears its `dma_mask` bit. If the start condition of R2 holds on that same check, DMA starts again at once from offset 0. Clearing `spr_en` while DMA runs does not stop it.
- R5: A sprite's pointer byte is read at `screen_base` + 0x3F8 + sprite index, in the first fetch cycle of that sprite.
- R6: The three image bytes of a sprite are read at (pointer × 64) + ((offset + k) mod 64) for k = 0, 1, 2, in consecutive cycles immediately after the pointer read.
- R7: After a check, only sprites whose new `dma_mask` bit is 1 are fetched, in ascending index order, with no idle cycle between sprites.
- R8: Each check swaps the front and back buffers. `spr_data[24*i+23:24*i]` then holds sprite i's bytes from the previous line's fetch: byte k=0 is in bits 23:16, k=1 in bits 15:8 and k=2 in bits 7:0.
- R9: `bus_req` and `mem_rd` are 1 from the cycle after a check for exactly 4 cycles per set `dma_mask` bit, and 0 otherwise.
- R10: `dma_mask` changes only on an accepted check. A `line_start` pulse that arrives while `bus_req` is 1 is ignored: the mask, the channel state, the buffers and the fetch in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at the line's sprite check point |
| raster_y | input | 8 | Low 8 bits of the current raster line |
| spr_en | input | 8 | Per-sprite enable |
| spr_ypos | input | 64 | Per-sprite Y position, sprite i in bits 8i+7:8i |
| spr_yexp | input | 8 | Per-sprite vertical expansion |
| screen_base | input | ADDR_W | Start of the character screen in video memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_data | input | 8 | Memory read data, same cycle |
| bus_req | output | 1 | Bus request while sprite fetches run |
| dma_mask | output | 8 | Channels in DMA on the current line |
| spr_data | output | 192 | Front buffer, 3 bytes per sprite |

## Verification
The bench goes after the line on which the offset reaches 63. A design that tests the old offset instead of the new one fetches one line too many, and a design that ignores the same-line restart leaves a one-line gap that shows up as a missing mask bit. Expanded sprites whose expansion bit flips in mid-DMA are swept to catch a toggle that is recomputed in the wrong order, which would show as an offset fetched three times or only once. Raster wrap past 255, disabled sprites whose Y matches, enable cleared during DMA, and a check pulse arriving while fetches are still running are each driven. For every fetch cycle, the address order, the pointer region and the wrap of the 64-byte row are compared against a model that the bench computes.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int NSPR    = 8;
    localparam int IDX_W   = $clog2(NSPR);
    localparam int OFF_W   = 6;
    localparam int NBYTES  = 3;
    localparam int WORD_W  = NBYTES * 8;
    localparam logic [OFF_W-1:0] OFF_LAST = 6'd63;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PTR,
        PH_D0,
        PH_D1,
        PH_D2
    } phase_e;

    typedef struct packed {
        logic             act;
        logic [OFF_W-1:0] off;
        logic             tog;
        logic [1:0]       inc;
    } chan_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [1:0] step_of(input logic tog);
        return tog ? 2'd3 : 2'd0;
    endfunction

    function automatic chan_t arm(input logic yexp);
        chan_t c;
        c.act = 1'b1;
        c.off = '0;
        c.tog = ~yexp;
        c.inc = step_of(~yexp);
        return c;
    endfunction

    // One line of channel state evolution at the check point.
    function automatic chan_t advance(input chan_t s, input logic hit, input logic yexp);
        chan_t n;
        n = s;
        if (!s.act) begin
            if (hit) n = arm(yexp);
        end else begin
            n.off = s.off + {{(OFF_W-2){1'b0}}, s.inc};
            n.tog = yexp ? ~s.tog : s.tog;
            n.inc = step_of(n.tog);
            if (n.off == OFF_LAST) begin
                n.act = 1'b0;
                if (hit) n = arm(yexp);
            end
        end
        return n;
    endfunction

    // Lowest set bit of m at or above position from.
    function automatic pick_t pick_from(input logic [NSPR-1:0] m, input int from);
        pick_t p;
        p = '0;
        for (int i = NSPR - 1; i >= 0; i--) begin
            if (m[i] && i >= from) begin
                p.hit = 1'b1;
                p.idx = i[IDX_W-1:0];
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/sdma_chan.sv
module sdma_chan
    import sdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chk,
    input  logic             en,
    input  logic             yexp,
    input  logic [7:0]       ypos,
    input  logic [7:0]       line_y,
    output logic             nxt_act,
    output logic [OFF_W-1:0] off
);

    chan_t st_q;
    chan_t st_d;
    logic  hit;

    assign hit = en && (ypos == line_y);

    always_comb begin
        st_d = advance(st_q, hit, yexp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (chk) begin
            st_q <= st_d;
        end
    end

    assign nxt_act = st_d.act;
    assign off     = st_q.off;

endmodule

// File: rtl/sdma_fetch.sv
module sdma_fetch
    import sdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NSPR-1:0]  new_mask,
    input  logic [NSPR-1:0]  mask,
    input  logic [7:0]       rd_data,
    output phase_e           phase,
    output logic [IDX_W-1:0] idx,
    output logic [7:0]       ptr
);

    pick_t first_p;
    pick_t next_p;

    always_comb begin
        first_p = pick_from(new_mask, 0);
        next_p  = pick_from(mask, int'(idx) + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            ptr   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start && first_p.hit) begin
                        phase <= PH_PTR;
                        idx   <= first_p.idx;
                    end
                end
                PH_PTR: begin
                    ptr   <= rd_data;
                    phase <= PH_D0;
                end
                PH_D0: phase <= PH_D1;
                PH_D1: phase <= PH_D2;
                PH_D2: begin
                    if (next_p.hit) begin
                        phase <= PH_PTR;
                        idx   <= next_p.idx;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdma_dbuf.sv
module sdma_dbuf
    import sdma_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   swap,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  logic [1:0]             wbyte,
    input  logic [7:0]             wdata,
    output logic [NSPR*WORD_W-1:0] front
);

    logic [7:0] bank [2][NSPR][NBYTES];
    logic       sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= 1'b0;
            for (int b = 0; b < 2; b++)
                for (int j = 0; j < NSPR; j++)
                    for (int k = 0; k < NBYTES; k++)
                        bank[b][j][k] <= '0;
        end else begin
            if (swap) sel <= ~sel;
            if (we) bank[~sel][widx][wbyte] <= wdata;
        end
    end

    always_comb begin
        front = '0;
        for (int j = 0; j < NSPR; j++)
            for (int k = 0; k < NBYTES; k++)
                front[j*WORD_W + (NBYTES-1-k)*8 +: 8] = bank[sel][j][k];
    end

endmodule

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
    import sdma_pkg::*;
#(
    parameter int          ADDR_W   = 14,
    parameter logic [9:0]  PTR_BASE = 10'h3F8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   line_start,
    input  logic [7:0]             raster_y,
    input  logic [NSPR-1:0]        spr_en,
    input  logic [NSPR*8-1:0]      spr_ypos,
    input  logic [NSPR-1:0]        spr_yexp,
    input  logic [ADDR_W-1:0]      screen_base,
    output logic                   mem_rd,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic [7:0]             mem_data,
    output logic                   bus_req,
    output logic [NSPR-1:0]        dma_mask,
    output logic [NSPR*WORD_W-1:0] spr_data
);

    localparam int DATA_SPAN = 8 + OFF_W;

    logic             accept;
    logic [NSPR-1:0]  nxt_act;
    logic [OFF_W-1:0] offs [NSPR];
    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic [7:0]       ptr;
    logic [1:0]       bsel;
    logic             in_data;
    logic [OFF_W-1:0] row_off;

    assign bus_req = (phase != PH_IDLE);
    assign mem_rd  = bus_req;
    assign accept  = line_start && !bus_req;

    for (genvar g = 0; g < NSPR; g++) begin : g_chan
        sdma_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .chk     (accept),
            .en      (spr_en[g]),
            .yexp    (spr_yexp[g]),
            .ypos    (spr_ypos[g*8 +: 8]),
            .line_y  (raster_y),
            .nxt_act (nxt_act[g]),
            .off     (offs[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) dma_mask <= '0;
        else if (accept) dma_mask <= nxt_act;
    end

    sdma_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .new_mask (nxt_act),
        .mask     (dma_mask),
        .rd_data  (mem_data),
        .phase    (phase),
        .idx      (idx),
        .ptr      (ptr)
    );

    always_comb begin
        in_data = 1'b1;
        bsel    = 2'd0;
        unique case (phase)
            PH_D0:   bsel = 2'd0;
            PH_D1:   bsel = 2'd1;
            PH_D2:   bsel = 2'd2;
            default: in_data = 1'b0;
        endcase
        row_off = offs[idx] + {{(OFF_W-2){1'b0}}, bsel};
    end

    always_comb begin
        if (phase == PH_PTR) begin
            mem_addr = screen_base + ADDR_W'(PTR_BASE) + ADDR_W'(idx);
        end else if (in_data) begin
            mem_addr = ADDR_W'({ptr, row_off});
        end else begin
            mem_addr = '0;
        end
    end

    sdma_dbuf u_dbuf (
        .clk   (clk),
        .rst   (rst),
        .swap  (accept),
        .we    (in_data),
        .widx  (idx),
        .wbyte (bsel),
        .wdata (mem_data),
        .front (spr_data)
    );

    if (ADDR_W < DATA_SPAN) begin : g_width_guard
        initial $error("ADDR_W too narrow for sprite data addresses");
    end

endmodule

// File: rtl/sprite_dma_seq_chk.sv
module sprite_dma_seq_chk
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              line_start,
    input logic              bus_req,
    input logic [NSPR-1:0]   dma_mask,
    input logic [ADDR_W-1:0] mem_addr,
    input phase_e            phase,
    input logic [IDX_W-1:0]  idx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (dma_mask == '0) && !bus_req);

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_start && !bus_req) |=> $stable(dma_mask));

    // R9
    req_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(line_start));

    // R7
    req_masked_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> dma_mask[idx]);

    // R7
    empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_mask == '0) |-> !bus_req);

    // R6
    byte_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_D1 || phase == PH_D2) |->
            (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 6'd1) &&
            (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

    // R9
    ptr_first_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_D0) |-> $past(phase) == PH_PTR);

endmodule

bind sprite_dma_seq sprite_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .bus_req    (bus_req),
    .dma_mask   (dma_mask),
    .mem_addr   (mem_addr),
    .phase      (phase),
    .idx        (idx)
);

// File: tb/sprite_dma_seq_test.sv
module sprite_dma_seq_test;

    localparam int AW = 14;
    localparam int N  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_start = 1'b0;
    logic [7:0]    raster_y = '0;
    logic [N-1:0]  spr_en = '0;
    logic [N-1:0]  spr_yexp = '0;
    logic [7:0]    ypos [N];
    logic [N*8-1:0] spr_ypos;
    logic [AW-1:0] screen_base = 14'h0400;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;
    logic          bus_req;
    logic [N-1:0]  dma_mask;
    logic [N*24-1:0] spr_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    bit         m_act [N];
    int         m_off [N];
    bit         m_tog [N];
    int         m_inc [N];
    bit         prev_ok [N];
    logic [23:0] prev_dat [N];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mfun(input logic [AW-1:0] a);
        return a[7:0] ^ {a[13:8], 2'b00} ^ 8'h5A;
    endfunction

    always_comb begin
        for (int j = 0; j < N; j++) spr_ypos[j*8 +: 8] = ypos[j];
    end
    assign mem_data = mfun(mem_addr);

    sprite_dma_seq uut (
        .clk(clk), .rst(rst), .line_start(line_start), .raster_y(raster_y),
        .spr_en(spr_en), .spr_ypos(spr_ypos), .spr_yexp(spr_yexp),
        .screen_base(screen_base), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_data), .bus_req(bus_req), .dma_mask(dma_mask),
        .spr_data(spr_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic start_ch(input int j);
        m_act[j] = 1;
        m_off[j] = 0;
        m_tog[j] = !spr_yexp[j];
        m_inc[j] = m_tog[j] ? 3 : 0;
    endtask

    task automatic model_line(input logic [7:0] ln);
        for (int j = 0; j < N; j++) begin
            bit hit;
            hit = spr_en[j] && (ypos[j] == ln);
            if (!m_act[j]) begin
                if (hit) start_ch(j);
            end else begin
                m_off[j] = (m_off[j] + m_inc[j]) % 64;
                if (spr_yexp[j]) m_tog[j] = !m_tog[j];
                m_inc[j] = m_tog[j] ? 3 : 0;
                if (m_off[j] == 63) begin
                    m_act[j] = 0;
                    if (hit) start_ch(j);
                end
            end
        end
    endtask

    task automatic run_line(input logic [8:0] ln, input bit poke);
        logic [N-1:0] em;
        logic [23:0]  cur [N];
        model_line(ln[7:0]);
        for (int j = 0; j < N; j++) em[j] = m_act[j];
        raster_y   = ln[7:0];
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        // R2 R4: mask after check
        chk(dma_mask == em, "R2/R4 mask", 32'(dma_mask), 32'(em));
        // R8: front now holds previous line's fetch
        for (int j = 0; j < N; j++)
            if (prev_ok[j])
                chk(spr_data[j*24 +: 24] == prev_dat[j], "R8 front", 32'(spr_data[j*24 +: 24]), 32'(prev_dat[j]));
        for (int j = 0; j < N; j++) begin
            if (em[j]) begin
                logic [AW-1:0] pa;
                logic [7:0]    p;
                pa = screen_base + 14'h3F8 + AW'(j);
                p  = mfun(pa);
                chk(bus_req && mem_rd, "R9 req", 32'({bus_req, mem_rd}), 32'h3);
                chk(mem_addr == pa, "R5/R7 ptr addr", 32'(mem_addr), 32'(pa));
                if (poke) line_start = 1'b1;
                @(negedge clk);
                line_start = 1'b0;
                poke = 0;
                for (int k = 0; k < 3; k++) begin
                    logic [AW-1:0] da;
                    da = {p, 6'((m_off[j] + k) % 64)};
                    cur[j][(2-k)*8 +: 8] = mfun(da);
                    chk(bus_req && mem_rd, "R9 req", 32'({bus_req, mem_rd}), 32'h3);
                    chk(mem_addr == da, "R3/R6 data addr", 32'(mem_addr), 32'(da));
                    @(negedge clk);
                end
            end
        end
        chk(!bus_req && !mem_rd, "R9 idle", 32'({bus_req, mem_rd}), 32'h0);
        // R10: a pulse during fetch left the mask alone
        chk(dma_mask == em, "R10 mask held", 32'(dma_mask), 32'(em));
        for (int j = 0; j < N; j++) begin
            prev_ok[j] = em[j];
            if (em[j]) prev_dat[j] = cur[j];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            ypos[j] = '0; m_act[j] = 0; m_off[j] = 0; m_tog[j] = 0; m_inc[j] = 0;
            prev_ok[j] = 0; prev_dat[j] = '0;
        end
        repeat (4) @(negedge clk);
        // R1: during reset
        chk(dma_mask == 0 && !bus_req && !mem_rd, "R1 in reset", 32'({dma_mask, bus_req}), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(dma_mask == 0 && !bus_req && spr_data == '0, "R1 after reset", 32'({dma_mask, bus_req}), 32'h0);

        // Sweep A: all eight, staggered starts, mixed expansion
        spr_en   = 8'hFF;
        spr_yexp = 8'b1010_0101;
        for (int j = 0; j < N; j++) ypos[j] = 8'(5 + 3 * j);
        for (int ln = 0; ln < 80; ln++) run_line(9'(ln), (ln % 7) == 3);

        // Sweep B: end at 63 with restart on the same line (R4)
        spr_en   = 8'h01;
        spr_yexp = 8'h00;
        ypos[0]  = 8'd100;
        for (int ln = 96; ln < 150; ln++) begin
            if (ln == 110) ypos[0] = 8'd121;
            run_line(9'(ln), 0);
        end

        // Sweep C: raster wrap, disabled match, enable dropped, expansion flipped
        screen_base = 14'h3800;
        spr_en   = 8'h0C;
        spr_yexp = 8'h08;
        ypos[2] = 8'd4;
        ypos[3] = 8'd250;
        ypos[4] = 8'd252;
        for (int ln = 248; ln < 330; ln++) begin
            if (ln == 255) spr_yexp[3] = 1'b0;
            if (ln == 262) spr_yexp[3] = 1'b1;
            if (ln == 265) spr_en[2] = 1'b0;
            run_line(9'(ln), (ln % 5) == 0);
        end

        // Sweep D: expansion toggled every line on all sprites
        screen_base = 14'h0000;
        spr_en = 8'hFF;
        for (int j = 0; j < N; j++) ypos[j] = 8'(20 + j);
        for (int ln = 18; ln < 90; ln++) begin
            spr_yexp = 8'(ln * 37);
            run_line(9'(ln), (ln % 4) == 1);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule